// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects a simple synchronous host request port to asynchronous parallel memories such as SRAM, NOR flash and NAND flash. It drives four active-low chip selects. The upper two bits of the host byte address pick the chip select, and each chip select covers a 64 MiB window. Every access runs through three phases: setup, strobe and hold. Each chip select has its own set of counts for these phases, one set for reads and one for writes, all measured in clock cycles.

Each chip select also has its own configuration for four further features:
- a turnaround count, inserted before an access that changes direction or chip select;
- an 8-bit or 16-bit data bus;
- a select-strobe mode, in which the chip select is driven only while the strobe is active;
- an extended-wait mode, in which a synchronized wait pin can stretch the strobe.

The host raises `req_i` with a direction, address and write data, and holds them until `done_o` pulses. If `req_i` stays high after `done_o`, the next access starts back-to-back. Configuration inputs are expected to stay static while an access is in progress.

Top module: `async_mem_ctrl`

## Requirements
- R1: Chip select index is host address bits [27:26]. At most one of `cs_no_o` is low at any time. `mem_addr_o` stays stable while a chip select stays low.
- R2: An access runs setup, then strobe, then hold. The widths come from the read or write counts of the selected chip select. `oe_no_o` is low only during a read strobe, and `we_no_o` only during a write strobe.
- R3: A setup, strobe or hold count of zero behaves exactly like a count of one.
- R4: Before an access starts, the controller inserts the turnaround count of the target chip select as idle cycles. It skips them when the access has the same direction and the same chip select as the previous access. Between two accesses there is always at least one cycle with every chip select high.
- R5: When select-strobe is enabled, the chip select is low only during the strobe cycles. Otherwise it is low for every setup, strobe and hold cycle.
- R6: When extended wait is enabled, the strobe does not end while the wait input, passed through two flops, is high. With a wait release three cycles after the strobe starts and a programmed strobe of 2, the strobe lasts 6 cycles. With extended wait disabled, the wait input has no effect.
- R7: In 16-bit mode `mem_addr_o` is the window byte offset shifted right by one, and all 16 data bits are used. In 8-bit mode `mem_addr_o` is the byte offset, `data_o[15:8]` is driven as zero, and `rdata_o[15:8]` reads as zero.
- R8: Read data is taken from `data_i` in the final strobe cycle, after any wait extension. It appears on `rdata_o` from the first hold cycle on.
- R9: `done_o` pulses for exactly one cycle, in the last hold cycle. `data_oe_o` is high for every setup, strobe and hold cycle of a write, and never during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 28 | Host byte address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rd_setup_i | input | 16 | Read setup count, 4 bits per chip select |
| rd_strobe_i | input | 16 | Read strobe count, 4 bits per chip select |
| rd_hold_i | input | 16 | Read hold count, 4 bits per chip select |
| wr_setup_i | input | 16 | Write setup count, 4 bits per chip select |
| wr_strobe_i | input | 16 | Write strobe count, 4 bits per chip select |
| wr_hold_i | input | 16 | Write hold count, 4 bits per chip select |
| turn_i | input | 16 | Turnaround count, 4 bits per chip select |
| wide_i | input | 4 | 1 = 16-bit bus, 0 = 8-bit bus |
| ss_mode_i | input | 4 | Select-strobe enable |
| ew_mode_i | input | 4 | Extended-wait enable |
| cs_no_o | output | 4 | Chip selects, active low |
| oe_no_o | output | 1 | Output enable, active low |
| we_no_o | output | 1 | Write enable, active low |
| mem_addr_o | output | 26 | Device address |
| data_o | output | 16 | Device write data |
| data_oe_o | output | 1 | Device data driver enable |
| data_i | input | 16 | Device read data |
| wait_i | input | 1 | Asynchronous wait from the device |

## Verification
The sharpest coincidence is the last strobe cycle of a read with extended wait. There, the synchronized wait falling, the strobe ending and the read-data capture all fall on the same clock edge. The bench holds the wait pin high and releases it a fixed number of cycles after output-enable falls. It then judges the strobe length and the captured data against each other: one stretch too many or too few shows up as a wrong strobe count. A second coincidence is the done pulse and the next request. The request is kept high through the done cycle, so the turnaround decision for the next access is taken right after the previous access is recorded. The bench judges this by the number of all-high chip-select cycles between accesses.

// File: rtl/amc_pkg.sv
package amc_pkg;
  parameter int unsigned AMC_CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD
  } amc_state_e;

  typedef struct packed {
    logic [AMC_CNT_W-1:0] setup;
    logic [AMC_CNT_W-1:0] strobe;
    logic [AMC_CNT_W-1:0] hold;
    logic [AMC_CNT_W-1:0] turn;
    logic                 wide;
    logic                 ss;
    logic                 ew;
  } amc_tim_t;
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/amc_cfg_mux.sv
module amc_cfg_mux
  import amc_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned CS_W   = 2
) (
  input  logic [CS_W-1:0]             sel_i,
  input  logic                        we_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] rd_setup_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] rd_strobe_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] rd_hold_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] wr_setup_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] wr_strobe_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] wr_hold_i,
  input  logic [NUM_CS*AMC_CNT_W-1:0] turn_i,
  input  logic [NUM_CS-1:0]           wide_i,
  input  logic [NUM_CS-1:0]           ss_i,
  input  logic [NUM_CS-1:0]           ew_i,
  output amc_tim_t                    tim_o
);
  localparam int unsigned W = AMC_CNT_W;

  amc_tim_t tbl [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign tbl[g] = '{
      setup:  we_i ? wr_setup_i[g*W +: W]  : rd_setup_i[g*W +: W],
      strobe: we_i ? wr_strobe_i[g*W +: W] : rd_strobe_i[g*W +: W],
      hold:   we_i ? wr_hold_i[g*W +: W]   : rd_hold_i[g*W +: W],
      turn:   turn_i[g*W +: W],
      wide:   wide_i[g],
      ss:     ss_i[g],
      ew:     ew_i[g]
    };
  end

  assign tim_o = tbl[sel_i];
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int unsigned CS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CS_W-1:0]  cs_i,
  input  amc_tim_t         tim_i,
  input  logic             wait_i,
  output amc_state_e       state_o,
  output logic [CS_W-1:0]  cs_o,
  output logic             we_o,
  output logic             wide_o,
  output logic             ss_o,
  output logic             accept_o,
  output logic             cap_o,
  output logic             done_o
);
  localparam int unsigned W = AMC_CNT_W;

  amc_state_e      state_q;
  logic [W-1:0]    cnt_q, setup_q, strobe_q, hold_q;
  logic            ew_q;
  logic [CS_W-1:0] cs_q, prev_cs_q;
  logic            we_q, wide_q, ss_q, prev_we_q, prev_vld_q;
  logic            cnt_zero, strobe_end, need_turn;

  // zero programs as one: load value is width-1, floored at 0
  function automatic logic [W-1:0] ld(input logic [W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  assign cnt_zero   = (cnt_q == '0);
  assign strobe_end = (state_q == ST_STROBE) && cnt_zero && !(ew_q && wait_i);
  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign need_turn  = prev_vld_q && !((prev_cs_q == cs_i) && (prev_we_q == we_i))
                      && (tim_i.turn != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      setup_q    <= '0;
      strobe_q   <= '0;
      hold_q     <= '0;
      ew_q       <= 1'b0;
      cs_q       <= '0;
      we_q       <= 1'b0;
      wide_q     <= 1'b0;
      ss_q       <= 1'b0;
      prev_cs_q  <= '0;
      prev_we_q  <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          cs_q     <= cs_i;
          we_q     <= we_i;
          wide_q   <= tim_i.wide;
          ss_q     <= tim_i.ss;
          ew_q     <= tim_i.ew;
          setup_q  <= tim_i.setup;
          strobe_q <= tim_i.strobe;
          hold_q   <= tim_i.hold;
          if (need_turn) begin
            state_q <= ST_TURN;
            cnt_q   <= tim_i.turn - 1'b1;
          end else begin
            state_q <= ST_SETUP;
            cnt_q   <= ld(tim_i.setup);
          end
        end
        ST_TURN: if (cnt_zero) begin
          state_q <= ST_SETUP;
          cnt_q   <= ld(setup_q);
        end else cnt_q <= cnt_q - 1'b1;
        ST_SETUP: if (cnt_zero) begin
          state_q <= ST_STROBE;
          cnt_q   <= ld(strobe_q);
        end else cnt_q <= cnt_q - 1'b1;
        ST_STROBE: if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (strobe_end) begin
            state_q <= ST_HOLD;
            cnt_q   <= ld(hold_q);
          end
        ST_HOLD: if (cnt_zero) begin
          state_q    <= ST_IDLE;
          prev_vld_q <= 1'b1;
          prev_cs_q  <= cs_q;
          prev_we_q  <= we_q;
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cs_o    = cs_q;
  assign we_o    = we_q;
  assign wide_o  = wide_q;
  assign ss_o    = ss_q;
  assign cap_o   = strobe_end && !we_q;
  assign done_o  = (state_q == ST_HOLD) && cnt_zero;
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = AMC_CNT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    done_o,
  input  logic [NUM_CS*CNT_W-1:0] rd_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_strobe_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_hold_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_strobe_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_hold_i,
  input  logic [NUM_CS*CNT_W-1:0] turn_i,
  input  logic [NUM_CS-1:0]       wide_i,
  input  logic [NUM_CS-1:0]       ss_mode_i,
  input  logic [NUM_CS-1:0]       ew_mode_i,
  output logic [NUM_CS-1:0]       cs_no_o,
  output logic                    oe_no_o,
  output logic                    we_no_o,
  output logic [ADDR_W-$clog2(NUM_CS)-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    data_oe_o,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    wait_i
);
  localparam int unsigned CS_W     = $clog2(NUM_CS);
  localparam int unsigned WIN_W    = ADDR_W - CS_W;
  localparam int unsigned NARROW_W = DATA_W / 2;

  amc_tim_t        tim;
  amc_state_e      state;
  logic [CS_W-1:0] cs_sel, cs_q;
  logic            we_q, wide_q, ss_q, accept, cap, wait_s;
  logic            in_access, in_strobe, cs_on;
  logic [WIN_W-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign cs_sel = addr_i[ADDR_W-1 -: CS_W];

  amc_wait_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wait_i), .q_o(wait_s)
  );

  amc_cfg_mux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cfg (
    .sel_i(cs_sel), .we_i(we_i),
    .rd_setup_i(rd_setup_i), .rd_strobe_i(rd_strobe_i), .rd_hold_i(rd_hold_i),
    .wr_setup_i(wr_setup_i), .wr_strobe_i(wr_strobe_i), .wr_hold_i(wr_hold_i),
    .turn_i(turn_i), .wide_i(wide_i), .ss_i(ss_mode_i), .ew_i(ew_mode_i),
    .tim_o(tim)
  );

  amc_seq #(.CS_W(CS_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .cs_i(cs_sel),
    .tim_i(tim), .wait_i(wait_s), .state_o(state), .cs_o(cs_q), .we_o(we_q),
    .wide_o(wide_q), .ss_o(ss_q), .accept_o(accept), .cap_o(cap), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i[WIN_W-1:0];
        wdata_q <= wdata_i;
      end
      if (cap) rdata_q <= wide_q ? data_i : {{(DATA_W-NARROW_W){1'b0}}, data_i[NARROW_W-1:0]};
    end
  end

  assign in_access = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign in_strobe = (state == ST_STROBE);
  assign cs_on     = ss_q ? in_strobe : in_access;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no_o[g] = !(cs_on && (cs_q == CS_W'(g)));
  end

  assign oe_no_o    = !(in_strobe && !we_q);
  assign we_no_o    = !(in_strobe && we_q);
  assign data_oe_o  = in_access && we_q;
  assign data_o     = wide_q ? wdata_q : {{(DATA_W-NARROW_W){1'b0}}, wdata_q[NARROW_W-1:0]};
  assign mem_addr_o = wide_q ? {1'b0, addr_q[WIN_W-1:1]} : addr_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned WIN_W  = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] cs_no_i,
  input logic              oe_no_i,
  input logic              we_no_i,
  input logic              data_oe_i,
  input logic              done_i,
  input logic [WIN_W-1:0]  mem_addr_i
);
  logic cs_any;
  assign cs_any = (cs_no_i != '1);

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no_i));

  assert_addr_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && $past(cs_any)) |-> $stable(mem_addr_i));

  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no_i && !we_no_i));

  assert_read_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no_i |-> !data_oe_i);

  assert_write_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no_i |-> data_oe_i);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_in_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (oe_no_i && we_no_i));
endmodule

bind async_mem_ctrl amc_checker #(.NUM_CS(NUM_CS), .WIN_W(WIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no_i(cs_no_o), .oe_no_i(oe_no_o),
  .we_no_i(we_no_o), .data_oe_i(data_oe_o), .done_i(done_o), .mem_addr_i(mem_addr_o)
);

// File: tb/async_mem_ctrl_tb_top.sv
module async_mem_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int CW  = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wait_i = 1'b0;
  logic [27:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, data_o, data_i;
  logic        done_o, oe_no_o, we_no_o, data_oe_o;
  logic [3:0]  cs_no_o;
  logic [25:0] mem_addr_o;
  logic [NCS*CW-1:0] rd_setup, rd_strobe, rd_hold, wr_setup, wr_strobe, wr_hold, turn;
  logic [NCS-1:0]    wide, ssm, ewm;

  int rs[4] = '{2, 0, 1, 3};
  int rt[4] = '{3, 0, 2, 1};
  int rh[4] = '{1, 0, 1, 2};
  int ws[4] = '{1, 0, 1, 2};
  int wt[4] = '{2, 0, 2, 4};
  int wh[4] = '{2, 0, 1, 1};
  int ta[4] = '{2, 3, 0, 1};
  bit wd_c[4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  bit ss_c[4] = '{1'b0, 1'b0, 1'b1, 1'b0};
  bit ew_c[4] = '{1'b0, 1'b0, 1'b1, 1'b0};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // device read model
  assign data_i = {~mem_addr_o[7:0], mem_addr_o[7:0]};

  async_mem_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
    .rd_setup_i(rd_setup), .rd_strobe_i(rd_strobe), .rd_hold_i(rd_hold),
    .wr_setup_i(wr_setup), .wr_strobe_i(wr_strobe), .wr_hold_i(wr_hold),
    .turn_i(turn), .wide_i(wide), .ss_mode_i(ssm), .ew_mode_i(ewm),
    .cs_no_o(cs_no_o), .oe_no_o(oe_no_o), .we_no_o(we_no_o), .mem_addr_o(mem_addr_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .data_i(data_i), .wait_i(wait_i)
  );

  typedef struct {
    int pre; int strb; int post; int gap; int cs; int doe;
    logic [25:0] addr; logic wr; logic [15:0] data;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  int prev_cs = -1;
  bit prev_wr = 1'b0;
  bit wait_arm = 1'b0;

  task automatic check(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // driver: push expectation, issue request, return at the done cycle
  task automatic access(input bit wr, input int cs, input logic [25:0] off,
                        input logic [15:0] wd, input bit first, input int strb_over);
    exp_t e;
    int s, t, h, applied;
    s = wr ? ws[cs] : rs[cs];
    t = wr ? wt[cs] : rt[cs];
    h = wr ? wh[cs] : rh[cs];
    e.strb = (strb_over > 0) ? strb_over : eff(t);
    e.pre  = ss_c[cs] ? 0 : eff(s);
    e.post = ss_c[cs] ? 0 : eff(h);
    applied = (prev_cs == cs && prev_wr == wr) ? 0 : ta[cs];
    e.gap  = first ? -1 : 1 + applied + (ss_c[cs] ? eff(s) : 0);
    e.doe  = wr ? eff(s) + e.strb + eff(h) : 0;
    e.cs   = cs;
    e.wr   = wr;
    e.addr = wd_c[cs] ? {1'b0, off[25:1]} : off;
    if (wr) e.data = wd_c[cs] ? wd : {8'h00, wd[7:0]};
    else    e.data = wd_c[cs] ? {~e.addr[7:0], e.addr[7:0]} : {8'h00, e.addr[7:0]};
    exp_q.push_back(e);
    req_i   = 1'b1;
    we_i    = wr;
    addr_i  = {cs[1:0], off};
    wdata_i = wd;
    do @(negedge clk_i); while (!done_o);
    prev_cs = cs;
    prev_wr = wr;
  endtask

  // monitor: measure each access at the pins, compare at done
  initial begin
    int gap_c = 0, pre_c = 0, strb_c = 0, post_c = 0, doe_c = 0, cs_seen = -1;
    bit started = 0, seen = 0;
    logic [25:0] a_cap = '0;
    logic [15:0] d_cap = '0;
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (!started && cs_no_o == 4'hf && oe_no_o && we_no_o) gap_c++;
        else begin
          started = 1;
          if (!oe_no_o || !we_no_o) begin
            seen = 1;
            strb_c++;
            a_cap = mem_addr_o;
            d_cap = data_o;
            for (int i = 0; i < NCS; i++) if (!cs_no_o[i]) cs_seen = i;
          end else if (cs_no_o != 4'hf) begin
            if (seen) post_c++;
            else      pre_c++;
          end
        end
        if (data_oe_o) doe_c++;
        if (done_o) begin
          if (exp_q.size() == 0) check("R9 done without request", 1, 0);
          else begin
            e = exp_q.pop_front();
            check("R1 chip select index", cs_seen, e.cs);
            check("R7 device address", a_cap, e.addr);
            check("R2 R3 R5 setup cycles with cs low", pre_c, e.pre);
            check("R2 R6 strobe cycles", strb_c, e.strb);
            check("R2 R3 R5 hold cycles with cs low", post_c, e.post);
            if (e.gap >= 0) check("R4 R5 idle cycles before access", gap_c, e.gap);
            check("R9 data_oe cycles", doe_c, e.doe);
            if (e.wr) check("R7 write data lanes", d_cap, e.data);
            else      check("R8 read data", rdata_o, e.data);
          end
          gap_c = 0; pre_c = 0; strb_c = 0; post_c = 0; doe_c = 0;
          cs_seen = -1; started = 0; seen = 0;
        end
      end
    end
  end

  // wait pin driver for R6: release 3 cycles after output enable falls
  initial begin
    forever begin
      @(negedge clk_i);
      if (wait_arm && !oe_no_o) begin
        repeat (3) @(negedge clk_i);
        wait_i   = 1'b0;
        wait_arm = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCS; i++) begin
      rd_setup[i*CW +: CW]  = rs[i][CW-1:0];
      rd_strobe[i*CW +: CW] = rt[i][CW-1:0];
      rd_hold[i*CW +: CW]   = rh[i][CW-1:0];
      wr_setup[i*CW +: CW]  = ws[i][CW-1:0];
      wr_strobe[i*CW +: CW] = wt[i][CW-1:0];
      wr_hold[i*CW +: CW]   = wh[i][CW-1:0];
      turn[i*CW +: CW]      = ta[i][CW-1:0];
      wide[i] = wd_c[i];
      ssm[i]  = ss_c[i];
      ewm[i]  = ew_c[i];
    end
    repeat (3) @(negedge clk_i);
    // reset state
    check("R1 reset cs_no", cs_no_o, 4'hf);
    check("R2 reset oe_no", oe_no_o, 1);
    check("R2 reset we_no", we_no_o, 1);
    check("R9 reset data_oe", data_oe_o, 0);
    check("R9 reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // back-to-back run: same/different direction and chip select
    access(0, 0, 26'h0000124, 16'h0000, 1, 0);
    access(0, 0, 26'h00001f8, 16'h0000, 0, 0);
    access(1, 0, 26'h0003456, 16'hbeef, 0, 0);
    access(1, 0, 26'h0003458, 16'h1234, 0, 0);
    access(0, 1, 26'h20000a5, 16'h0000, 0, 0);  // zero counts, 8-bit
    access(1, 3, 26'h0000077, 16'hc3a9, 0, 0);  // 8-bit write lanes
    access(0, 3, 26'h3ffff3c, 16'h0000, 0, 0);
    access(0, 2, 26'h0000342, 16'h0000, 0, 0);  // select-strobe
    access(1, 1, 26'h0000011, 16'h5a5a, 0, 0);
    req_i = 1'b0;
    repeat (6) @(negedge clk_i);

    // R6: wait held high; ignored on cs0, stretches cs2 read strobe to 6
    wait_i   = 1'b1;
    wait_arm = 1'b1;
    repeat (4) @(negedge clk_i);
    access(1, 0, 26'h0000200, 16'h7e81, 1, 0);
    access(0, 2, 26'h00000f0, 16'h0000, 0, 6);
    req_i = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R9 all accesses completed", exp_q.size(), 0);
    check("R9 done idle", done_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule